// File: doc/BRIEF.md
# Three-Lane Serial Result Readout

This block is the device-side serial shifter that hands six 16-bit conversion results to a host. A load strobe captures a new set of results together with a mask of which channel pairs were converted and a resolution setting. From then on the host frames reads with an active-low chip select and clocks bits out with SCLK. The block oversamples CS and SCLK on its own system clock, which is assumed to run several times faster than SCLK and to see both inputs already synchronised.

Up to three data lanes carry the stream. The lane-enable inputs choose one, two or three lanes, and that choice fixes which results travel on which lane and how many SCLKs a full read takes (96, 48 or 32). The bit position is shared by all lanes and survives the end of a frame. A read can therefore be split into several shorter CS frames or done in one long frame. Slots for unconverted pairs and every clock after the last slot shift out zeros.

Top module: `result_serial_out`

## Requirements
- R1: While `cs_n` is high, every bit of `dout_oe` is 0 and `dout` is 0.
- R2: While `cs_n` is low, exactly the lanes used by the current lane mode have their `dout_oe` bit set. Mode three uses lanes 0,1,2, mode two uses lanes 0,1, and mode one uses lane 0.
- R3: Each result is 16 bits sent MSB first. The bit position advances by one on each SCLK falling edge seen while `cs_n` is low. SCLK edges while `cs_n` is high do not move it.
- R4: `res_mode` 2'b00 sends the full word. 2'b01 forces the top 2 bits to zero and keeps bits 13:0. 2'b10 and 2'b11 force the top 4 bits to zero and keep bits 11:0.
- R5: In mode three (`lane_en`=3'b111), lane 0 carries results 0 then 1, lane 1 carries 2 then 3, and lane 2 carries 4 then 5. The full read is 32 SCLKs.
- R6: In mode two (`lane_en`=3'b011), lane 0 carries results 0, 1, 4 and lane 1 carries results 2, 3, 5, each in that order. The full read is 48 SCLKs.
- R7: In mode one (`lane_en[0]`=1 and not mode two or three), lane 0 carries results 0 to 5 in order. The full read is 96 SCLKs.
- R8: Once all slots of the lane mode have been sent, further SCLKs output zeros. The position saturates and never wraps.
- R9: The results of a pair whose `pair_valid` bit (bit p covers results 2p and 2p+1) was 0 at load still occupy their slots and are sent as zeros.
- R10: The bit position is kept across CS frames. Only `load` returns it to the MSB of the first slot, and it does so even in the middle of a read.
- R11: `lane_en` combinations outside the three modes fall back as follows. Lane 0 enabled gives mode one. Lane 0 disabled gives no lane driven. A disabled lane never has `dout_oe` set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples SCLK and CS |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Captures a new result set and resets the position |
| result_words | input | 6x16 | The six conversion results, index 0 first |
| pair_valid | input | 3 | Converted-pair mask, bit p for results 2p, 2p+1 |
| res_mode | input | 2 | Resolution: 00 full, 01 14-bit, 1x 12-bit |
| lane_en | input | 3 | Lane enables for lanes 0, 1, 2 |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock; data advances on its falling edge |
| dout | output | 3 | Serial data, one bit per lane |
| dout_oe | output | 3 | Output enable per lane; 0 means high impedance |

## Verification
A wrong bit position shows on the very next sampled bit of every driven lane. The stream then stays shifted for the rest of the read, so a step lost across a frame boundary or an SCLK counted while deselected appears within one SCLK period of the next frame. A wrong lane-to-slot mapping or a missing pair mask shows only in the slot it affects, so the bench reads every slot of every mode and continues past the end to see the zero fill. Enable faults show as soon as `cs_n` changes, because `dout_oe` is combinational from `cs_n` and the lane enables.

// File: rtl/rdo_pkg.sv
package rdo_pkg;

    localparam int CH_N    = 6;
    localparam int WORD_W  = 16;
    localparam int LANE_N  = 3;
    localparam int PAIR_N  = CH_N / 2;
    localparam int POS_MAX = CH_N * WORD_W;
    localparam int POS_W   = $clog2(POS_MAX + 1);
    localparam int CH_W    = $clog2(CH_N);
    localparam int BIT_W   = $clog2(WORD_W);
    localparam int SLOT_W  = POS_W - BIT_W;

    typedef enum logic [1:0] {
        RES_FULL      = 2'b00,
        RES_DROP2     = 2'b01,
        RES_DROP4     = 2'b10,
        RES_DROP4_ALT = 2'b11
    } res_mode_e;

    typedef enum logic [1:0] {
        LANES_NONE,
        LANES_ONE,
        LANES_TWO,
        LANES_THREE
    } lane_mode_e;

    typedef struct packed {
        logic            hit;
        logic [CH_W-1:0] ch;
    } slot_src_t;

    // Blank the bits above the active resolution.
    function automatic logic [WORD_W-1:0] fmt_word(logic [WORD_W-1:0] raw, res_mode_e m);
        logic [WORD_W-1:0] keep;
        case (m)
            RES_FULL:  keep = '1;
            RES_DROP2: keep = {2'b00, {(WORD_W-2){1'b1}}};
            default:   keep = {4'b0000, {(WORD_W-4){1'b1}}};
        endcase
        return raw & keep;
    endfunction

    function automatic lane_mode_e decode_lanes(logic [LANE_N-1:0] en);
        if (en == 3'b111)      return LANES_THREE;
        if (en[1:0] == 2'b11)  return LANES_TWO;
        if (en[0])             return LANES_ONE;
        return LANES_NONE;
    endfunction

    function automatic logic [LANE_N-1:0] drive_mask(lane_mode_e m);
        case (m)
            LANES_THREE: return 3'b111;
            LANES_TWO:   return 3'b011;
            LANES_ONE:   return 3'b001;
            default:     return 3'b000;
        endcase
    endfunction

    // Which result occupies a given slot of a given lane.
    function automatic slot_src_t lane_source(lane_mode_e m, int lane, logic [SLOT_W-1:0] slot);
        slot_src_t s;
        s.hit = 1'b0;
        s.ch  = '0;
        case (m)
            LANES_THREE: if (slot < 2) begin
                s.hit = 1'b1;
                s.ch  = CH_W'(2*lane + int'(slot));
            end
            LANES_TWO: if (lane < 2 && slot < 3) begin
                s.hit = 1'b1;
                s.ch  = (slot == 2) ? CH_W'(4 + lane) : CH_W'(2*lane + int'(slot));
            end
            LANES_ONE: if (lane == 0 && slot < SLOT_W'(CH_N)) begin
                s.hit = 1'b1;
                s.ch  = CH_W'(slot);
            end
            default: ;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/rdo_capture.sv
module rdo_capture
    import rdo_pkg::*;
#(
    parameter int N_CH = CH_N,
    parameter int W    = WORD_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      load,
    input  logic [N_CH-1:0][W-1:0]    raw_words,
    input  logic [N_CH/2-1:0]         pair_valid,
    input  res_mode_e                 res_mode,
    output logic [N_CH-1:0][W-1:0]    words
);

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) begin
                words[i] <= '0;
            end else if (load) begin
                words[i] <= pair_valid[i/2] ? fmt_word(raw_words[i], res_mode) : '0;
            end
        end
    end

    // R9: a masked pair is stored as zeros.
    for (genvar p = 0; p < N_CH/2; p++) begin : g_chk
        p_masked_pair_zero_r9: assert property (@(posedge clk) disable iff (rst)
            (load && !pair_valid[p]) |=> (words[2*p] == '0 && words[2*p+1] == '0));
    end

endmodule

// File: rtl/rdo_bitpos.sv
module rdo_bitpos #(
    parameter int POS_LIMIT = 96,
    parameter int PW        = $clog2(POS_LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          cs_n,
    input  logic          sclk,
    output logic [PW-1:0] pos
);

    logic sclk_q;
    logic sclk_fall;

    always_ff @(posedge clk) begin
        if (rst) sclk_q <= 1'b0;
        else     sclk_q <= sclk;
    end

    assign sclk_fall = sclk_q & ~sclk;

    always_ff @(posedge clk) begin
        if (rst || load) begin
            pos <= '0;
        end else if (!cs_n && sclk_fall && pos != PW'(POS_LIMIT)) begin
            pos <= pos + 1'b1;
        end
    end

    p_load_restarts_r10: assert property (@(posedge clk) disable iff (rst)
        load |=> pos == '0);

    p_hold_deselected_r3: assert property (@(posedge clk) disable iff (rst)
        (!load && cs_n) |=> pos == $past(pos));

    p_never_past_end_r8: assert property (@(posedge clk) disable iff (rst)
        pos <= PW'(POS_LIMIT));

    p_single_step_r3: assert property (@(posedge clk) disable iff (rst)
        (!load && !cs_n && pos < PW'(POS_LIMIT)) |=>
            (pos == $past(pos) || pos == $past(pos) + 1'b1));

endmodule

// File: rtl/rdo_lane_mux.sv
module rdo_lane_mux
    import rdo_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic [POS_W-1:0]               pos,
    input  logic [CH_N-1:0][WORD_W-1:0]    words,
    input  lane_mode_e                     mode,
    input  logic                           cs_n,
    output logic [LANE_N-1:0]              dout,
    output logic [LANE_N-1:0]              dout_oe
);

    logic [LANE_N-1:0]  mask;
    logic [SLOT_W-1:0]  slot;
    logic [BIT_W-1:0]   bit_sel;

    assign mask    = drive_mask(mode);
    assign slot    = pos[POS_W-1:BIT_W];
    assign bit_sel = BIT_W'(WORD_W-1) - pos[BIT_W-1:0];

    for (genvar l = 0; l < LANE_N; l++) begin : g_lane
        slot_src_t src;
        logic      data;
        always_comb begin
            src  = lane_source(mode, l, slot);
            data = src.hit ? words[src.ch][bit_sel] : 1'b0;
        end
        assign dout_oe[l] = ~cs_n & mask[l];
        assign dout[l]    = dout_oe[l] & data;

        // R8: once past the last slot of the lane, only zeros leave.
        p_tail_zero_r8: assert property (@(posedge clk) disable iff (rst)
            (pos == POS_W'(POS_MAX)) |-> dout[l] == 1'b0);
    end

    p_idle_hiz_r1: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> (dout_oe == '0 && dout == '0));

endmodule

// File: rtl/result_serial_out.sv
module result_serial_out
    import rdo_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         load,
    input  logic [CH_N-1:0][WORD_W-1:0]  result_words,
    input  logic [PAIR_N-1:0]            pair_valid,
    input  logic [1:0]                   res_mode,
    input  logic [LANE_N-1:0]            lane_en,
    input  logic                         cs_n,
    input  logic                         sclk,
    output logic [LANE_N-1:0]            dout,
    output logic [LANE_N-1:0]            dout_oe
);

    logic [CH_N-1:0][WORD_W-1:0] words;
    logic [POS_W-1:0]            pos;
    lane_mode_e                  mode;

    assign mode = decode_lanes(lane_en);

    rdo_capture #(.N_CH(CH_N), .W(WORD_W)) u_capture (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .raw_words (result_words),
        .pair_valid(pair_valid),
        .res_mode  (res_mode_e'(res_mode)),
        .words     (words)
    );

    rdo_bitpos #(.POS_LIMIT(POS_MAX), .PW(POS_W)) u_bitpos (
        .clk (clk),
        .rst (rst),
        .load(load),
        .cs_n(cs_n),
        .sclk(sclk),
        .pos (pos)
    );

    rdo_lane_mux u_mux (
        .clk    (clk),
        .rst    (rst),
        .pos    (pos),
        .words  (words),
        .mode   (mode),
        .cs_n   (cs_n),
        .dout   (dout),
        .dout_oe(dout_oe)
    );

    p_enable_respected_r11: assert property (@(posedge clk) disable iff (rst)
        (dout_oe & ~lane_en) == '0);

    p_lane0_needed_r11: assert property (@(posedge clk) disable iff (rst)
        !lane_en[0] |-> dout_oe == '0);

endmodule

// File: tb/tb_result_serial_out.sv
module tb_result_serial_out;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst, load, cs_n, sclk;
    logic [5:0][15:0]  result_words;
    logic [2:0]        pair_valid, lane_en, dout, dout_oe;
    logic [1:0]        res_mode;

    result_serial_out dut (
        .clk(clk), .rst(rst), .load(load), .result_words(result_words),
        .pair_valid(pair_valid), .res_mode(res_mode), .lane_en(lane_en),
        .cs_n(cs_n), .sclk(sclk), .dout(dout), .dout_oe(dout_oe)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [15:0] m_raw [6];
    logic [2:0]  m_valid;
    logic [1:0]  m_res;
    int          m_k;

    function automatic int exp_ch(logic [2:0] en, int lane, int slot);
        if (en == 3'b111) begin
            if (slot < 2) return 2*lane + slot;
        end else if (en[1:0] == 2'b11) begin
            if (lane == 0 && slot < 3) return (slot == 2) ? 4 : slot;
            if (lane == 1 && slot < 3) return (slot == 2) ? 5 : 2 + slot;
        end else if (en[0]) begin
            if (lane == 0 && slot < 6) return slot;
        end
        return -1;
    endfunction

    function automatic bit exp_drive(logic [2:0] en, int lane);
        if (en == 3'b111) return 1'b1;
        if (en[1:0] == 2'b11) return lane < 2;
        if (en[0]) return lane == 0;
        return 1'b0;
    endfunction

    function automatic bit exp_bit(logic [2:0] en, int lane, int k);
        int ch = exp_ch(en, lane, k / 16);
        int b  = 15 - (k % 16);
        if (k >= 96 || ch < 0) return 1'b0;
        if (!m_valid[ch/2]) return 1'b0;
        if (m_res == 2'b01 && b >= 14) return 1'b0;
        if (m_res[1] && b >= 12) return 1'b0;
        return m_raw[ch][b];
    endfunction

    function automatic string tag(logic [2:0] en, int lane, int k);
        int ch = exp_ch(en, lane, k / 16);
        int b  = 15 - (k % 16);
        if (ch < 0) return "R8";
        if (!m_valid[ch/2]) return "R9";
        if ((m_res == 2'b01 && b >= 14) || (m_res[1] && b >= 12)) return "R4";
        if (en == 3'b111) return "R5";
        if (en == 3'b011) return "R6";
        if (en == 3'b001) return "R7";
        return "R11";
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_lanes();
        for (int l = 0; l < 3; l++) begin
            bit eo = !cs_n && exp_drive(lane_en, l);
            string r = cs_n ? "R1" : ((lane_en == 3'b111 || lane_en == 3'b011 || lane_en == 3'b001) ? "R2" : "R11");
            chk(dout_oe[l] == eo, r, $sformatf("oe lane%0d en=%b", l, lane_en), dout_oe[l], eo);
            if (eo) begin
                bit ed = exp_bit(lane_en, l, m_k);
                chk(dout[l] == ed, tag(lane_en, l, m_k),
                    $sformatf("data lane%0d k=%0d en=%b res=%0d", l, m_k, lane_en, m_res), dout[l], ed);
            end else begin
                chk(dout[l] == 1'b0, "R1", $sformatf("quiet lane%0d", l), dout[l], 0);
            end
        end
    endtask

    task automatic do_load(logic [2:0] v, logic [1:0] r);
        @(negedge clk);
        for (int i = 0; i < 6; i++) begin
            m_raw[i] = 16'($urandom);
            result_words[i] = m_raw[i];
        end
        m_valid = v; m_res = r;
        pair_valid = v; res_mode = r; load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        m_k = 0;
    endtask

    task automatic frame(int n);
        @(negedge clk);
        cs_n = 1'b0;
        @(negedge clk);
        check_lanes();
        for (int i = 0; i < n; i++) begin
            sclk = 1'b1;
            @(negedge clk); @(negedge clk);
            check_lanes();
            sclk = 1'b0;
            @(negedge clk); @(negedge clk);
            if (m_k < 96) m_k++;
        end
        check_lanes();
        cs_n = 1'b1;
        @(negedge clk);
        check_lanes();
    endtask

    task automatic idle_clocks(int n);
        for (int i = 0; i < n; i++) begin
            sclk = 1'b1; @(negedge clk); @(negedge clk);
            sclk = 1'b0; @(negedge clk); @(negedge clk);
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [2:0] en_pick [9] = '{3'b111, 3'b011, 3'b001, 3'b101, 3'b110, 3'b000, 3'b111, 3'b011, 3'b001};
        void'($urandom(32'h1F2E3D4C));
        rst = 1'b1; load = 1'b0; cs_n = 1'b1; sclk = 1'b0;
        result_words = '0; pair_valid = '0; res_mode = '0; lane_en = 3'b111;
        for (int i = 0; i < 6; i++) m_raw[i] = '0;
        m_valid = '0; m_res = '0; m_k = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // Reset state: deselected lanes quiet (R1), stored words are zero.
        check_lanes();
        m_valid = 3'b111;
        frame(4);

        // R4: resolution modes with all-ones words, mode three (R5).
        for (int r = 0; r < 4; r++) begin
            do_load(3'b111, 2'(r));
            for (int i = 0; i < 6; i++) begin m_raw[i] = 16'hFFFF; end
            @(negedge clk);
            result_words = {6{16'hFFFF}}; load = 1'b1;
            @(negedge clk); load = 1'b0; m_k = 0;
            lane_en = 3'b111;
            frame(34);
        end

        // R10 and R3: split frames with SCLK toggling while deselected.
        lane_en = 3'b001;
        do_load(3'b101, 2'b00);
        frame(20);
        idle_clocks(5);
        frame(30);
        // R10: load in mid-read restarts at the first slot.
        do_load(3'b111, 2'b00);
        frame(18);
        // R8 with mode one: run to the end and beyond.
        frame(96);

        // Random mix of modes, masks, resolutions and frame splits.
        for (int it = 0; it < 30; it++) begin
            int total, left;
            lane_en = en_pick[$urandom_range(0, 8)];
            do_load(3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)));
            total = (lane_en == 3'b111) ? 40 : (lane_en[1:0] == 2'b11) ? 56 : 104;
            left = total;
            while (left > 0) begin
                int n = ($urandom_range(0, 2) == 0) ? left : (($urandom_range(0, 1) == 0) ? 16 : 32);
                if (n > left) n = left;
                frame(n);
                if ($urandom_range(0, 3) == 0) idle_clocks(3);
                left -= n;
            end
        end

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule